// File: doc/BRIEF.md
# Link Test-Mode Receive Checker

This block watches one lane of an 8b/10b converter link while the link runs one of its data-link test modes. Each cycle it takes one decoded character (an 8-bit value, a control-character flag and a valid strobe) and a 3-bit test-mode code. It keeps three counters: characters received in error, complete initial lane alignment (ILA) sequences received, and ILA multiframes received. A small select input places any one of them on a read output.

In the continuous-comma mode every character must be the comma K28.5. In the repeated-ILA mode the checker first waits for comma traffic to give way to the start-of-multiframe marker K28.0. It then follows the ILA structure given by the frame size F, the multiframe size K and the number of multiframes per sequence. It checks each character against what its position calls for, and it counts multiframes and whole sequences as they end. Entering an active test mode clears the counts for that mode. Leaving it freezes them so they can be read afterwards.

Top module: `ila_test_checker`

## Requirements
- R1: After reset all three counters read zero.
- R2: With mode code 3'b001, each valid character other than K28.5 (data 8'hBC with the control flag set) adds one to the error counter.
- R3: In the first cycle with code 3'b001 or 3'b010 after a different code, the error counter clears. On entry to 3'b010 the sequence and multiframe counters also clear and alignment restarts. The character presented in that cycle is not examined. When the mode moves to any other code, all counts keep their values.
- R4: In mode 3'b010, before alignment, K28.5 is accepted silently. K28.0 (8'h1C, control) is taken as position 0 of multiframe 0, and any other valid character counts one error.
- R5: Once aligned, a multiframe spans K*F characters. Position 0 must be K28.0. The last position must be K28.3 (8'h7C, control). Position 1 of multiframe 1 must be K28.4 (8'h9C, control). Every other position must be a data character with the control flag clear. Any other character counts one error. Position 0 takes precedence over the last position, and the last position takes precedence over position 1.
- R6: The multiframe counter adds one on the last character of each multiframe in mode 3'b010, whether that character matched or not.
- R7: The sequence counter adds one on the last character of multiframe N-1, where N is the programmed count plus one. The next expected character is then position 0 of multiframe 0 again.
- R8: Characters without the valid strobe change no counter and do not advance the position.
- R9: With any code other than 3'b001 and 3'b010, no counter changes.
- R10: Every counter stops at its all-ones value instead of wrapping.
- R11: Select 0 reads the error counter, select 1 the sequence counter, select 2 the multiframe counter and select 3 reads zero, with no cycle of latency.
- R12: A mismatching character in mode 3'b010 does not realign the checker; the position still advances by one.
- R13: F and K are programmed minus one (F up to 256, K up to 32), and so is N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode | input | 3 | Test-mode code |
| ch_valid | input | 1 | Character strobe |
| ch_k | input | 1 | Control-character flag |
| ch_data | input | 8 | Decoded character |
| oct_per_frm_m1 | input | 8 | F minus one |
| frm_per_mf_m1 | input | 5 | K minus one |
| ila_mf_m1 | input | 8 | ILA multiframes per sequence minus one |
| rd_sel | input | 2 | Counter select |
| rd_data | output | CNT_W | Selected counter |

## Verification
The bench hits the entry cycle of each active mode to catch a checker that counts the character seen while the mode changes. It moves between the two active modes directly, which would expose a design that clears only on leaving normal mode. It injects errors at the /Q/ slot and at a data slot. A checker that resynchronised on an error, or that checked /Q/ in the wrong multiframe, would then lose its sequence count. A single-octet-frame layout puts the /Q/ slot in the second frame rather than the second octet. Saturation is reached on a narrow counter, so a wrapping counter would read small values. Idle cycles and unused mode codes between bursts must leave every count untouched.

// File: rtl/ila_test_checker.sv
module ila_test_checker #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       test_mode,
  input  logic             ch_valid,
  input  logic             ch_k,
  input  logic [7:0]       ch_data,
  input  logic [7:0]       oct_per_frm_m1,
  input  logic [4:0]       frm_per_mf_m1,
  input  logic [7:0]       ila_mf_m1,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data
);
  localparam logic [2:0] MODE_COMMA = 3'b001;
  localparam logic [2:0] MODE_ILA   = 3'b010;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  logic [2:0]       mode_q;
  logic [CNT_W-1:0] err_q, seq_q, mf_q;
  logic [7:0]       oct_q;
  logic [4:0]       frm_q;
  logic [7:0]       mfi_q;
  logic             aligned_q;

  logic active, ila, entry, look;
  logic is_comma, is_r, is_a, is_q;
  logic at_first, at_last, at_second, slot_ok, bad;
  logic adv, mf_end, seq_end;

  assign active   = (test_mode == MODE_COMMA) || (test_mode == MODE_ILA);
  assign ila      = (test_mode == MODE_ILA);
  assign entry    = active && (test_mode != mode_q);
  assign look     = ch_valid && !entry;

  assign is_comma = ch_k && (ch_data == 8'hBC);
  assign is_r     = ch_k && (ch_data == 8'h1C);
  assign is_a     = ch_k && (ch_data == 8'h7C);
  assign is_q     = ch_k && (ch_data == 8'h9C);

  assign at_first  = (oct_q == 8'd0) && (frm_q == 5'd0);
  assign at_last   = (oct_q == oct_per_frm_m1) && (frm_q == frm_per_mf_m1);
  assign at_second = ((oct_q == 8'd1) && (frm_q == 5'd0)) ||
                     ((oct_per_frm_m1 == 8'd0) && (oct_q == 8'd0) && (frm_q == 5'd1));

  always_comb begin
    if (at_first)                          slot_ok = is_r;
    else if (at_last)                      slot_ok = is_a;
    else if (mfi_q == 8'd1 && at_second)   slot_ok = is_q;
    else                                   slot_ok = !ch_k;
  end

  always_comb begin
    if (!ila)            bad = !is_comma;
    else if (aligned_q)  bad = !slot_ok;
    else                 bad = !(is_comma || is_r);
  end

  assign adv     = ila && look && (aligned_q || is_r);
  assign mf_end  = adv && at_last;
  assign seq_end = mf_end && (mfi_q == ila_mf_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= 3'b000;
      aligned_q <= 1'b0;
      oct_q     <= '0;
      frm_q     <= '0;
      mfi_q     <= '0;
    end else begin
      mode_q <= test_mode;
      if (entry && ila) begin
        aligned_q <= 1'b0;
        oct_q     <= '0;
        frm_q     <= '0;
        mfi_q     <= '0;
      end else if (adv) begin
        aligned_q <= 1'b1;
        if (oct_q == oct_per_frm_m1) begin
          oct_q <= '0;
          if (frm_q == frm_per_mf_m1) begin
            frm_q <= '0;
            mfi_q <= (mfi_q == ila_mf_m1) ? 8'd0 : mfi_q + 8'd1;
          end else begin
            frm_q <= frm_q + 5'd1;
          end
        end else begin
          oct_q <= oct_q + 8'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= '0;
      seq_q <= '0;
      mf_q  <= '0;
    end else if (entry) begin
      err_q <= '0;
      if (ila) begin
        seq_q <= '0;
        mf_q  <= '0;
      end
    end else begin
      if (active && look && bad && err_q != CNT_MAX) err_q <= err_q + CNT_ONE;
      if (mf_end && mf_q != CNT_MAX)                 mf_q  <= mf_q + CNT_ONE;
      if (seq_end && seq_q != CNT_MAX)               seq_q <= seq_q + CNT_ONE;
    end
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = err_q;
      2'd1:    rd_data = seq_q;
      2'd2:    rd_data = mf_q;
      default: rd_data = '0;
    endcase
  end

  assert_entry_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> (err_q == '0));

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> ($stable(err_q) && $stable(seq_q) && $stable(mf_q)));

  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q == CNT_MAX && !entry) |=> (err_q == CNT_MAX));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !entry |=> (err_q == $past(err_q) || err_q == $past(err_q) + CNT_ONE));

  assert_seq_only_ila_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ila |=> $stable(seq_q));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_valid && !entry) |=> ($stable(err_q) && $stable(mf_q) && $stable(oct_q) && $stable(frm_q)));
endmodule

// File: tb/ila_test_checker_test.sv
`timescale 1ns/1ps
module ila_test_checker_test;
  localparam int W = 6;
  localparam int MAXV = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] test_mode = 3'b000;
  logic ch_valid = 1'b0, ch_k = 1'b0;
  logic [7:0] ch_data = 8'h00;
  logic [7:0] oct_per_frm_m1 = 8'd1;
  logic [4:0] frm_per_mf_m1 = 5'd3;
  logic [7:0] ila_mf_m1 = 8'd3;
  logic [1:0] rd_sel = 2'd0;
  logic [W-1:0] rd_data;

  int checks = 0, errors = 0;
  int m_err = 0, m_seq = 0, m_mf = 0, m_prev = 0, m_run = 0, m_p = 0, m_m = 0;
  int rot = 0;

  ila_test_checker #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .ch_valid(ch_valid), .ch_k(ch_k),
    .ch_data(ch_data), .oct_per_frm_m1(oct_per_frm_m1), .frm_per_mf_m1(frm_per_mf_m1),
    .ila_mf_m1(ila_mf_m1), .rd_sel(rd_sel), .rd_data(rd_data));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sat(input int v);
    return (v >= MAXV) ? MAXV : v + 1;
  endfunction

  task automatic model;
    int md, len, nmf;
    bit isbc, isr, bad, ok;
    md = int'(test_mode);
    len = (int'(oct_per_frm_m1) + 1) * (int'(frm_per_mf_m1) + 1);
    nmf = int'(ila_mf_m1) + 1;
    isbc = ch_k && ch_data == 8'hBC;
    isr  = ch_k && ch_data == 8'h1C;
    if ((md == 1 || md == 2) && md != m_prev) begin
      m_err = 0;
      if (md == 2) begin m_seq = 0; m_mf = 0; m_run = 0; m_p = 0; m_m = 0; end
    end else if ((md == 1 || md == 2) && ch_valid) begin
      if (md == 1) bad = !isbc;
      else if (m_run == 0) begin
        bad = !(isbc || isr);
        if (isr) m_run = 1;
      end else begin
        if (m_p == 0)                ok = isr;
        else if (m_p == len - 1)     ok = ch_k && ch_data == 8'h7C;
        else if (m_m == 1 && m_p == 1) ok = ch_k && ch_data == 8'h9C;
        else                         ok = !ch_k;
        bad = !ok;
      end
      if (bad) m_err = sat(m_err);
      if (md == 2 && m_run == 1) begin
        if (m_p == len - 1) begin
          m_p = 0;
          m_mf = sat(m_mf);
          if (m_m == nmf - 1) begin m_m = 0; m_seq = sat(m_seq); end
          else m_m++;
        end else m_p++;
      end
    end
    m_prev = md;
  endtask

  task automatic step(input logic v, input logic kk, input logic [7:0] d);
    int exp;
    ch_valid = v; ch_k = kk; ch_data = d; rd_sel = 2'(rot);
    @(posedge clk);
    model();
    #1;
    exp = (rot == 0) ? m_err : (rot == 1) ? m_seq : (rot == 2) ? m_mf : 0;
    chk("R11 per-cycle", int'(rd_data), exp);
    rot = (rot + 1) % 4;
  endtask

  task automatic peek(input logic [1:0] s, input int exp, input string req);
    rd_sel = s; #0.5;
    chk(req, int'(rd_data), exp);
  endtask

  task automatic send_seq(input int ea_m, input int ea_p, input int eb_m, input int eb_p);
    int len, nmf;
    logic kk; logic [7:0] d;
    len = (int'(oct_per_frm_m1) + 1) * (int'(frm_per_mf_m1) + 1);
    nmf = int'(ila_mf_m1) + 1;
    for (int m = 0; m < nmf; m++)
      for (int p = 0; p < len; p++) begin
        if (p == 0)                begin kk = 1; d = 8'h1C; end
        else if (p == len - 1)     begin kk = 1; d = 8'h7C; end
        else if (m == 1 && p == 1) begin kk = 1; d = 8'h9C; end
        else                       begin kk = 0; d = 8'(8'h20 + p); end
        if ((m == ea_m && p == ea_p) || (m == eb_m && p == eb_p)) kk = ~kk;
        step(1'b1, kk, d);
      end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    peek(2'd0, 0, "R1 err"); peek(2'd1, 0, "R1 seq"); peek(2'd2, 0, "R1 mf");

    test_mode = 3'b001;
    step(1'b1, 1'b0, 8'h00);
    peek(2'd0, 0, "R3 entry char ignored");
    repeat (5) step(1'b1, 1'b1, 8'hBC);
    step(1'b1, 1'b0, 8'hBC); step(1'b1, 1'b1, 8'h1C); step(1'b1, 1'b0, 8'h55);
    peek(2'd0, 3, "R2 comma errors");
    repeat (4) step(1'b0, 1'b0, 8'h55);
    peek(2'd0, 3, "R8 invalid ignored");

    test_mode = 3'b000;
    repeat (5) step(1'b1, 1'b0, 8'h11);
    peek(2'd0, 3, "R3 hold on exit");
    test_mode = 3'b101;
    repeat (5) step(1'b1, 1'b0, 8'h11);
    peek(2'd0, 3, "R9 unused code frozen");

    test_mode = 3'b001;
    step(1'b1, 1'b0, 8'h11);
    peek(2'd0, 0, "R3 clear on re-entry");
    repeat (70) step(1'b1, 1'b0, 8'h42);
    peek(2'd0, MAXV, "R10 saturation");

    test_mode = 3'b010;
    step(1'b1, 1'b0, 8'h42);
    peek(2'd0, 0, "R3 entry 001 to 010");
    repeat (3) step(1'b1, 1'b1, 8'hBC);
    step(1'b1, 1'b0, 8'h55);
    peek(2'd0, 1, "R4 hunt garbage");
    send_seq(-1, -1, -1, -1);
    peek(2'd1, 1, "R7 sequence count"); peek(2'd2, 4, "R6 multiframe count");
    peek(2'd0, 1, "R5 clean sequence");
    send_seq(1, 1, 2, 3);
    peek(2'd0, 3, "R5 injected errors");
    peek(2'd1, 2, "R12 no realign"); peek(2'd2, 8, "R6 second sequence");
    repeat (3) step(1'b0, 1'b1, 8'h1C);
    peek(2'd2, 8, "R8 idle in ila");

    test_mode = 3'b000;
    repeat (4) step(1'b1, 1'b1, 8'h1C);
    peek(2'd1, 2, "R3 seq hold"); peek(2'd2, 8, "R9 mf frozen");

    oct_per_frm_m1 = 8'd0; frm_per_mf_m1 = 5'd2; ila_mf_m1 = 8'd1;
    test_mode = 3'b010;
    step(1'b1, 1'b1, 8'h1C);
    peek(2'd1, 0, "R3 seq cleared"); peek(2'd2, 0, "R3 mf cleared");
    step(1'b1, 1'b1, 8'hBC);
    send_seq(-1, -1, -1, -1);
    send_seq(-1, -1, -1, -1);
    peek(2'd0, 0, "R13 F=1 layout"); peek(2'd1, 2, "R7 F=1 sequences");
    peek(2'd2, 4, "R6 F=1 multiframes");
    peek(2'd3, 0, "R11 select 3");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule